// File: doc/BRIEF.md
# Memory Request Page Splitter

This block turns one large memory transfer command into a series of legal memory request header descriptors. A command gives a starting byte address, a total transfer size in doublewords (DW), a read/write direction, a traffic class and two ordering/caching attribute bits. The block cuts the transfer into chunks. No chunk runs past a 4 KiB address page, and no chunk is longer than a maximum payload set by a parameter.

For each chunk the block produces one descriptor beat. The beat carries the chunk address, the encoded length field and the header format: three DW for addresses below 4 GiB, four DW otherwise. It also carries the posted flag, the copied attributes and a flag that marks the final chunk. The upstream side and the downstream side each use a valid/ready handshake. The block holds one command at a time.

Top module: `mrq_boundary_splitter`

## Requirements
- R1: The block ignores the two low bits of the command address and treats them as zero. The first chunk starts at that address, and each later chunk starts at the previous chunk address plus 4 × its DW length. No chunk extends past a 4 KiB-aligned address boundary.
- R2: Each chunk length in DW is the smallest of three values: the DWs still to send, the DWs left before the next 4 KiB boundary, and the MAX_PAYLOAD_DW parameter (1 to 1024).
- R3: `req_len` is a 10-bit field that holds the chunk length. A length of 1024 DW is encoded as 0, and lengths 1 to 1023 are encoded as themselves.
- R4: `req_hdr4dw` is 0 (3-DW header) when bits 63:32 of the chunk address are all zero. Otherwise it is 1 (4-DW header). The choice is made for each chunk on its own.
- R5: `req_is_write` repeats the command direction (1 = write). `req_posted` is 1 for write chunks and 0 for read chunks.
- R6: `req_tc`, `req_ro` and `req_ns` equal the command's traffic class and attribute bits on every chunk.
- R7: `req_last` is 1 only on the final chunk of a command. The chunk lengths add up to the command DW count.
- R8: `cmd_ready` goes low in the cycle after a non-zero command is accepted. It stays low until the final chunk has been taken. A command offered during that time has no effect.
- R9: A command with a DW count of 0 is accepted and raises `cmd_err` for exactly one cycle, the cycle after acceptance. It produces no descriptor, and `cmd_ready` stays high.
- R10: While `req_valid` is high and `req_ready` is low, every descriptor output holds its value.
- R11: During reset, `req_valid` and `cmd_err` are 0 and `cmd_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block can accept a command |
| cmd_addr | input | ADDR_W | Starting byte address |
| cmd_dw_count | input | CNT_W | Total transfer size in DW |
| cmd_is_write | input | 1 | 1 = write, 0 = read |
| cmd_tc | input | 3 | Traffic class |
| cmd_ro | input | 1 | Relaxed ordering attribute |
| cmd_ns | input | 1 | No-snoop attribute |
| cmd_err | output | 1 | One-cycle pulse for a zero-size command |
| req_valid | output | 1 | Descriptor valid |
| req_ready | input | 1 | Descriptor consumed |
| req_addr | output | ADDR_W | Chunk byte address |
| req_len | output | 10 | Encoded chunk length (0 means 1024) |
| req_hdr4dw | output | 1 | 1 = 4-DW header, 0 = 3-DW header |
| req_posted | output | 1 | 1 = posted (no completion expected) |
| req_is_write | output | 1 | Chunk direction |
| req_tc | output | 3 | Traffic class |
| req_ro | output | 1 | Relaxed ordering attribute |
| req_ns | output | 1 | No-snoop attribute |
| req_last | output | 1 | Final chunk of the command |

## Verification
The hardest cases to reach are chunks where two limits hit at once. One is a chunk whose length is exactly 1024 DW, so it needs the zero encoding. The other is a transfer that starts just below the 4 GiB line, so its header format changes partway through the command. Two instances take the same command stream: one caps the payload at 128 DW and the other allows 1024. Directed commands place page-aligned and near-4 GiB starts, and random commands bias their addresses towards page ends and the 4 GiB line. The downstream ready signal is held low for long stretches and also toggled at random, so descriptors are held and commands arrive while the block is busy.

// File: rtl/mrq_split_pkg.sv
package mrq_split_pkg;
   localparam int PAGE_BYTES  = 4096;
   localparam int PAGE_DW     = PAGE_BYTES / 4;
   localparam int PAGE_OFF_W  = $clog2(PAGE_DW);
   localparam int CHUNK_W     = PAGE_OFF_W + 1;
   localparam int LEN_FIELD_W = PAGE_OFF_W;
   localparam int TC_W        = 3;

   typedef struct packed {
      logic [TC_W-1:0] tc;
      logic            ro;
      logic            ns;
      logic            is_write;
   } mrq_attr_t;

   function automatic logic [LEN_FIELD_W-1:0] encode_len(input logic [CHUNK_W-1:0] dw);
      return dw[LEN_FIELD_W-1:0];
   endfunction
endpackage

// File: rtl/mrq_chunk_len.sv
module mrq_chunk_len
   import mrq_split_pkg::*;
#(
   parameter int CNT_W          = 16,
   parameter int MAX_PAYLOAD_DW = 256
) (
   input  logic [PAGE_OFF_W-1:0] page_dw_off,
   input  logic [CNT_W-1:0]      remaining,
   output logic [CHUNK_W-1:0]    chunk_dw,
   output logic                  is_last
);
   localparam logic [CHUNK_W-1:0] PAGE_LIM = CHUNK_W'(PAGE_DW);
   localparam logic [CHUNK_W-1:0] CAP_LIM  = CHUNK_W'(MAX_PAYLOAD_DW);

   logic [CHUNK_W-1:0] rem_cap;
   logic [CHUNK_W-1:0] to_boundary;
   logic [CHUNK_W-1:0] page_min;

   always_comb begin
      rem_cap     = (remaining >= CNT_W'(PAGE_DW)) ? PAGE_LIM : remaining[CHUNK_W-1:0];
      to_boundary = PAGE_LIM - {1'b0, page_dw_off};
      page_min    = (rem_cap < to_boundary) ? rem_cap : to_boundary;
   end

   generate
      if (MAX_PAYLOAD_DW < PAGE_DW) begin : g_capped
         assign chunk_dw = (page_min > CAP_LIM) ? CAP_LIM : page_min;
      end else begin : g_uncapped
         assign chunk_dw = page_min;
      end
   endgenerate

   assign is_last = (CNT_W'(chunk_dw) == remaining);
endmodule

// File: rtl/mrq_hdr_sel.sv
module mrq_hdr_sel
   import mrq_split_pkg::*;
#(
   parameter int ADDR_W = 64,
   localparam int HI_W  = (ADDR_W > 32) ? ADDR_W - 32 : 1
) (
   input  logic [HI_W-1:0]        addr_hi,
   input  logic [CHUNK_W-1:0]     chunk_dw,
   input  mrq_attr_t              attr,
   output logic                   hdr4dw,
   output logic                   posted,
   output logic [LEN_FIELD_W-1:0] len_field
);
   generate
      if (ADDR_W > 32) begin : g_wide
         assign hdr4dw = |addr_hi;
      end else begin : g_narrow
         assign hdr4dw = 1'b0;
      end
   endgenerate

   assign posted    = attr.is_write;
   assign len_field = encode_len(chunk_dw);
endmodule

// File: rtl/mrq_boundary_splitter.sv
module mrq_boundary_splitter
   import mrq_split_pkg::*;
#(
   parameter int ADDR_W         = 64,
   parameter int CNT_W          = 16,
   parameter int MAX_PAYLOAD_DW = 256
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cmd_valid,
   output logic                   cmd_ready,
   input  logic [ADDR_W-1:0]      cmd_addr,
   input  logic [CNT_W-1:0]       cmd_dw_count,
   input  logic                   cmd_is_write,
   input  logic [2:0]             cmd_tc,
   input  logic                   cmd_ro,
   input  logic                   cmd_ns,
   output logic                   cmd_err,
   output logic                   req_valid,
   input  logic                   req_ready,
   output logic [ADDR_W-1:0]      req_addr,
   output logic [9:0]             req_len,
   output logic                   req_hdr4dw,
   output logic                   req_posted,
   output logic                   req_is_write,
   output logic [2:0]             req_tc,
   output logic                   req_ro,
   output logic                   req_ns,
   output logic                   req_last
);
   localparam int HI_W = (ADDR_W > 32) ? ADDR_W - 32 : 1;

   generate
      if (MAX_PAYLOAD_DW < 1 || MAX_PAYLOAD_DW > PAGE_DW) begin : g_bad_max
         $error("MAX_PAYLOAD_DW must lie in 1..1024");
      end
      if (ADDR_W < 12 || ADDR_W > 64) begin : g_bad_addr
         $error("ADDR_W must lie in 12..64");
      end
      if (CNT_W < CHUNK_W) begin : g_bad_cnt
         $error("CNT_W must be at least 11");
      end
   endgenerate

   logic              busy_q;
   logic [ADDR_W-1:0] addr_q;
   logic [CNT_W-1:0]  rem_q;
   mrq_attr_t         attr_q;
   logic              err_q;

   logic [CHUNK_W-1:0] chunk_dw;
   logic               chunk_last;
   logic [HI_W-1:0]    addr_hi;
   logic               cmd_fire;
   logic               out_fire;
   mrq_attr_t          cmd_attr;

   generate
      if (ADDR_W > 32) begin : g_hi
         assign addr_hi = addr_q[ADDR_W-1:32];
      end else begin : g_nohi
         assign addr_hi = '0;
      end
   endgenerate

   mrq_chunk_len #(
      .CNT_W          (CNT_W),
      .MAX_PAYLOAD_DW (MAX_PAYLOAD_DW)
   ) u_len (
      .page_dw_off (addr_q[PAGE_OFF_W+1:2]),
      .remaining   (rem_q),
      .chunk_dw    (chunk_dw),
      .is_last     (chunk_last)
   );

   mrq_hdr_sel #(
      .ADDR_W (ADDR_W)
   ) u_hdr (
      .addr_hi   (addr_hi),
      .chunk_dw  (chunk_dw),
      .attr      (attr_q),
      .hdr4dw    (req_hdr4dw),
      .posted    (req_posted),
      .len_field (req_len)
   );

   assign cmd_attr = '{tc: cmd_tc, ro: cmd_ro, ns: cmd_ns, is_write: cmd_is_write};
   assign cmd_fire = cmd_valid & ~busy_q;
   assign out_fire = busy_q & req_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         addr_q <= '0;
         rem_q  <= '0;
         attr_q <= '0;
         err_q  <= 1'b0;
      end else begin
         err_q <= cmd_fire && (cmd_dw_count == '0);
         if (cmd_fire && (cmd_dw_count != '0)) begin
            busy_q <= 1'b1;
            addr_q <= cmd_addr & ~ADDR_W'(3);
            rem_q  <= cmd_dw_count;
            attr_q <= cmd_attr;
         end else if (out_fire) begin
            addr_q <= addr_q + ADDR_W'({chunk_dw, 2'b00});
            rem_q  <= rem_q - CNT_W'(chunk_dw);
            if (chunk_last) begin
               busy_q <= 1'b0;
            end
         end
      end
   end

   assign cmd_ready    = ~busy_q;
   assign cmd_err      = err_q;
   assign req_valid    = busy_q;
   assign req_addr     = addr_q;
   assign req_is_write = attr_q.is_write;
   assign req_tc       = attr_q.tc;
   assign req_ro       = attr_q.ro;
   assign req_ns       = attr_q.ns;
   assign req_last     = chunk_last;
endmodule

// File: rtl/mrq_split_checker.sv
module mrq_split_checker #(
   parameter int ADDR_W         = 64,
   parameter int MAX_PAYLOAD_DW = 256
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_ready,
   input logic              cmd_err,
   input logic              req_valid,
   input logic              req_ready,
   input logic [ADDR_W-1:0] req_addr,
   input logic [9:0]        req_len,
   input logic              req_hdr4dw,
   input logic              req_last
);
   logic [10:0] dlen;
   assign dlen = (req_len == 10'd0) ? 11'd1024 : {1'b0, req_len};

   AST_PAGE_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> ({2'b00, req_addr[11:2]} + {1'b0, dlen}) <= 12'd1024); // R1

   AST_DW_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> req_addr[1:0] == 2'b00); // R1

   AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready && !req_last |=>
         req_valid && (req_addr == $past(req_addr) + ADDR_W'({$past(dlen), 2'b00}))); // R1

   AST_MAX_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> dlen <= 11'(MAX_PAYLOAD_DW)); // R2

   AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !req_ready |=>
         req_valid && $stable(req_addr) && $stable(req_len) && $stable(req_last)); // R10

   AST_BUSY_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> !cmd_ready); // R8

   AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_err |-> !req_valid && cmd_ready); // R9

   AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_err |=> !cmd_err || $past(cmd_ready)); // R9

   generate
      if (ADDR_W > 32) begin : g_fmt
         AST_SHORT_HDR: assert property (@(posedge clk) disable iff (!rst_n)
            req_valid && !req_hdr4dw |-> req_addr[ADDR_W-1:32] == '0); // R4
      end
   endgenerate
endmodule

bind mrq_boundary_splitter mrq_split_checker #(
   .ADDR_W         (ADDR_W),
   .MAX_PAYLOAD_DW (MAX_PAYLOAD_DW)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cmd_ready  (cmd_ready),
   .cmd_err    (cmd_err),
   .req_valid  (req_valid),
   .req_ready  (req_ready),
   .req_addr   (req_addr),
   .req_len    (req_len),
   .req_hdr4dw (req_hdr4dw),
   .req_last   (req_last)
);

// File: tb/mrq_boundary_splitter_bench.sv
module mrq_boundary_splitter_bench;
   localparam int AW = 64;
   localparam int CW = 16;
   localparam int MAXD [2] = '{128, 1024};

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic           rst_n;
   logic           cmd_valid;
   logic [AW-1:0]  cmd_addr;
   logic [CW-1:0]  cmd_cnt;
   logic           cmd_wr;
   logic [2:0]     cmd_tc;
   logic           cmd_ro;
   logic           cmd_ns;
   logic           rdy     [2];
   logic           o_cready[2];
   logic           o_err   [2];
   logic           o_valid [2];
   logic [AW-1:0]  o_addr  [2];
   logic [9:0]     o_len   [2];
   logic           o_hdr   [2];
   logic           o_posted[2];
   logic           o_wr    [2];
   logic [2:0]     o_tc    [2];
   logic           o_ro    [2];
   logic           o_ns    [2];
   logic           o_last  [2];

   mrq_boundary_splitter #(.ADDR_W(AW), .CNT_W(CW), .MAX_PAYLOAD_DW(128)) u_mrq_boundary_splitter (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(o_cready[0]),
      .cmd_addr(cmd_addr), .cmd_dw_count(cmd_cnt), .cmd_is_write(cmd_wr), .cmd_tc(cmd_tc),
      .cmd_ro(cmd_ro), .cmd_ns(cmd_ns), .cmd_err(o_err[0]), .req_valid(o_valid[0]),
      .req_ready(rdy[0]), .req_addr(o_addr[0]), .req_len(o_len[0]), .req_hdr4dw(o_hdr[0]),
      .req_posted(o_posted[0]), .req_is_write(o_wr[0]), .req_tc(o_tc[0]), .req_ro(o_ro[0]),
      .req_ns(o_ns[0]), .req_last(o_last[0]));

   mrq_boundary_splitter #(.ADDR_W(AW), .CNT_W(CW), .MAX_PAYLOAD_DW(1024)) u_mrq_boundary_splitter_full (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(o_cready[1]),
      .cmd_addr(cmd_addr), .cmd_dw_count(cmd_cnt), .cmd_is_write(cmd_wr), .cmd_tc(cmd_tc),
      .cmd_ro(cmd_ro), .cmd_ns(cmd_ns), .cmd_err(o_err[1]), .req_valid(o_valid[1]),
      .req_ready(rdy[1]), .req_addr(o_addr[1]), .req_len(o_len[1]), .req_hdr4dw(o_hdr[1]),
      .req_posted(o_posted[1]), .req_is_write(o_wr[1]), .req_tc(o_tc[1]), .req_ro(o_ro[1]),
      .req_ns(o_ns[1]), .req_last(o_last[1]));

   typedef struct {
      longint unsigned addr;
      int              len;
      bit              last;
   } exp_t;

   exp_t q0[$];
   exp_t q1[$];
   bit [2:0] e_tc [2];
   bit       e_ro [2];
   bit       e_ns [2];
   bit       e_wr [2];
   bit       e_err[2];
   int       vectors = 0;
   int       fails = 0;
   bit       live = 1'b0;
   int       ready_mode = 1;

   task automatic plan(input int k, input longint unsigned a, input int cnt);
      longint unsigned ad;
      int rem;
      int tb;
      int ln;
      exp_t e;
      ad  = a & ~64'd3;
      rem = cnt;
      while (rem > 0) begin
         tb = 1024 - int'((ad % 64'd4096) / 64'd4);
         ln = rem;
         if (tb < ln) ln = tb;
         if (MAXD[k] < ln) ln = MAXD[k];
         e.addr = ad;
         e.len  = ln;
         e.last = (ln == rem);
         if (k == 0) q0.push_back(e); else q1.push_back(e);
         ad  = ad + longint'(ln) * 4;
         rem = rem - ln;
      end
   endtask

   function automatic void miss(input int k, input string req, input string what,
                                input longint unsigned act, input longint unsigned exp, inout bit bad);
      $display("FAIL %s inst%0d %s: actual %0h expected %0h", req, k, what, act, exp);
      bad = 1'b1;
   endfunction

   function automatic void check(input int k);
      bit   qe;
      bit   bad;
      exp_t f;
      int   dl;
      bad = 1'b0;
      qe  = (k == 0) ? (q0.size() == 0) : (q1.size() == 0);
      vectors++;
      if (o_cready[k] != qe) miss(k, "R8", "cmd_ready", o_cready[k], qe, bad);
      if (o_err[k] != e_err[k]) miss(k, "R9", "cmd_err", o_err[k], e_err[k], bad);
      if (o_valid[k] != !qe) miss(k, "R7", "req_valid", o_valid[k], !qe, bad);
      if (!qe && o_valid[k]) begin
         f  = (k == 0) ? q0[0] : q1[0];
         dl = (o_len[k] == 10'd0) ? 1024 : int'(o_len[k]);
         if (o_addr[k] != f.addr) miss(k, "R1", "req_addr", o_addr[k], f.addr, bad);
         if (dl != f.len) miss(k, "R2", "chunk length", dl, f.len, bad);
         if (o_len[k] != 10'(f.len)) miss(k, "R3", "req_len field", o_len[k], 10'(f.len), bad);
         if (o_hdr[k] != ((f.addr >> 32) != 0)) miss(k, "R4", "req_hdr4dw", o_hdr[k], (f.addr >> 32) != 0, bad);
         if (o_posted[k] != e_wr[k]) miss(k, "R5", "req_posted", o_posted[k], e_wr[k], bad);
         if (o_wr[k] != e_wr[k]) miss(k, "R5", "req_is_write", o_wr[k], e_wr[k], bad);
         if (o_tc[k] != e_tc[k]) miss(k, "R6", "req_tc", o_tc[k], e_tc[k], bad);
         if (o_ro[k] != e_ro[k] || o_ns[k] != e_ns[k])
            miss(k, "R6", "ro/ns", {o_ro[k], o_ns[k]}, {e_ro[k], e_ns[k]}, bad);
         if (o_last[k] != f.last) miss(k, "R7", "req_last", o_last[k], f.last, bad);
      end
      if (bad) fails++;
   endfunction

   always @(negedge clk) begin
      if (live) begin
         for (int k = 0; k < 2; k++) begin
            check(k);
            e_err[k] = 1'b0;
            if (cmd_valid && o_cready[k]) begin
               if (cmd_cnt == '0) begin
                  e_err[k] = 1'b1;
               end else begin
                  e_tc[k] = cmd_tc; e_ro[k] = cmd_ro; e_ns[k] = cmd_ns; e_wr[k] = cmd_wr;
                  plan(k, cmd_addr, int'(cmd_cnt));
               end
            end
            if (o_valid[k] && rdy[k]) begin
               if (k == 0 && q0.size() > 0) void'(q0.pop_front());
               if (k == 1 && q1.size() > 0) void'(q1.pop_front());
            end
         end
      end
   end

   initial begin
      rdy[0] = 1'b1;
      rdy[1] = 1'b1;
      forever begin
         @(posedge clk);
         #1;
         for (int k = 0; k < 2; k++) begin
            case (ready_mode)
               0:       rdy[k] = ($urandom % 2) == 0;
               1:       rdy[k] = 1'b1;
               default: rdy[k] = 1'b0;
            endcase
         end
      end
   end

   task automatic send(input longint unsigned a, input int cnt, input bit wr,
                       input bit [2:0] tc, input bit ro, input bit ns);
      do begin
         @(posedge clk);
         #1;
      end while (!(o_cready[0] && o_cready[1]));
      cmd_addr = a; cmd_cnt = CW'(cnt); cmd_wr = wr; cmd_tc = tc; cmd_ro = ro; cmd_ns = ns;
      cmd_valid = 1'b1;
      @(posedge clk);
      #1;
      cmd_valid = 1'b0;
      // R8: a command offered while both are busy must be dropped
      if (!o_cready[0] && !o_cready[1]) begin
         cmd_addr = 64'h0000_0000_0000_0040; cmd_cnt = 16'd7; cmd_wr = ~wr; cmd_tc = ~tc;
         cmd_valid = 1'b1;
         @(posedge clk);
         #1;
         cmd_valid = 1'b0;
      end
   endtask

   task automatic drain();
      do begin
         @(posedge clk);
         #1;
      end while (!(q0.size() == 0 && q1.size() == 0 && o_cready[0] && o_cready[1]));
      repeat (3) @(posedge clk);
      #1;
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL R7 watchdog: actual still running expected finished");
      finish_run();
   end

   initial begin
      longint unsigned a;
      int c;
      rst_n = 1'b0; cmd_valid = 1'b0; cmd_addr = '0; cmd_cnt = '0;
      cmd_wr = 1'b0; cmd_tc = '0; cmd_ro = 1'b0; cmd_ns = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      for (int k = 0; k < 2; k++) begin
         vectors++;
         if (o_valid[k] !== 1'b0 || o_err[k] !== 1'b0 || o_cready[k] !== 1'b1) begin
            fails++;
            $display("FAIL R11 inst%0d reset outputs: actual v%b e%b r%b expected v0 e0 r1",
                     k, o_valid[k], o_err[k], o_cready[k]);
         end
      end
      @(posedge clk);
      #1;
      rst_n = 1'b1;
      live  = 1'b1;

      send(64'h1000, 1, 1'b1, 3'd0, 1'b0, 1'b0);                 // single DW, R7
      send(64'hFFC, 2, 1'b0, 3'd1, 1'b1, 1'b0);                  // last DW of a page, R1
      send(64'h0, 1024, 1'b1, 3'd5, 1'b1, 1'b1);                 // full page, R3 and R2 cap
      send(64'h800, 1024, 1'b0, 3'd2, 1'b0, 1'b1);               // two halves, R1
      send(64'hFFFF_F800, 1024, 1'b1, 3'd7, 1'b0, 1'b0);         // crosses 4 GiB, R4
      send(64'h12_3456_7000, 3000, 1'b0, 3'd3, 1'b1, 1'b1);      // high memory read, R4 R5
      send(64'h1003, 5, 1'b1, 3'd4, 1'b0, 1'b1);                 // low bits ignored, R1
      send(64'h2000, 0, 1'b1, 3'd0, 1'b0, 1'b0);                 // zero size, R9
      drain();

      ready_mode = 2;                                            // hold outputs, R10
      send(64'h3F00, 700, 1'b1, 3'd6, 1'b1, 1'b0);
      repeat (20) @(posedge clk);
      #1;
      ready_mode = 0;
      drain();

      for (int n = 0; n < 250; n++) begin
         case ($urandom % 4)
            0:       a = {32'h0, 32'($urandom)};
            1:       a = 64'hFFFF_F000 + 64'($urandom % 8192);
            2:       a = {32'($urandom), 32'($urandom)};
            default: a = 64'($urandom % 1000) * 64'd4096 + 64'd4096 - 64'd4 * 64'($urandom % 8);
         endcase
         c = (($urandom % 10) == 0) ? int'($urandom % 2) : 1 + int'($urandom % 3000);
         send(a, c, 1'($urandom), 3'($urandom), 1'($urandom), 1'($urandom));
      end
      drain();
      finish_run();
   end
endmodule